// File: doc/BRIEF.md
# DMA Channel Enable and Status Control

This block holds the control and status state of one DMA channel and decides when that channel may move data. Software reaches it through a small 32-bit register port with three registers. The control register has a channel enable, a transfer-end flag and an interrupt enable. The count register holds the remaining transfer units. The vector register holds the 8-bit interrupt vector. The block does not generate addresses or move data. It raises `xferBusy` to start one transfer unit, and the external data path reports the end of that unit with a one-cycle `xferDone` strobe.

A unit starts only when all of these hold: the channel enable is 1, the global master enable is 1, the global NMI and address-error flags are 0, the end flag is 0 and the count is non-zero. In auto mode the unit starts on these conditions alone. In request mode the block also waits for `xferReq`. When the count reaches zero on a normal completion, the end flag is set. The interrupt output is high while the end flag and the interrupt enable are both set, and the vector is presented beside it.

Software clears the end flag with a two-step handshake: it reads the flag as 1, then writes 0. A full standby clears the channel enable. Module standby freezes the block. The vector survives every kind of reset.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After a hardware reset (`rstN` low) the control register (address 0) reads 0, the count register (address 1) reads 0, and `xferBusy` and `irqOut` are 0.
- R2: In auto mode (`reqMode`=0), the block raises `xferBusy` on the first clock edge at which all start conditions hold. The conditions are: control bit 0 (enable) is 1, `masterEn` is 1, `nmiFlag` and `addrErrFlag` are 0, control bit 1 (end flag) is 0, and the count is non-zero.
- R3: In request mode (`reqMode`=1), `xferBusy` stays 0 until `xferReq` is sampled high while all the R2 conditions hold. It rises at that same edge.
- R4: `xferBusy` does not rise while the enable or `masterEn` is 0, or while `nmiFlag`, `addrErrFlag` or the end flag is 1.
- R5: While busy, an `xferDone` strobe drops `xferBusy` and decrements the count. When the count goes from 1 to 0 on a normal completion, the end flag is set.
- R6: A write to the control register clears the end flag only if it has bit 1 = 0 and the previous control access was a read that returned bit 1 = 1. Any other write leaves the end flag unchanged.
- R7: If the enable is cleared, or a global gate closes, while a unit is busy, `xferBusy` stays high until `xferDone` arrives. That completion decrements the count but does not set the end flag, and no new unit starts.
- R8: A high `standbyEnter` clears the enable at the next edge. While `modStandby` is high, all register state and the busy state hold, and register writes are ignored.
- R9: The vector register (address 2) stores only write bits 7:0, and bits 31:8 read 0. Its contents survive a hardware reset. Address 3 reads 0.
- R10: `irqOut` equals end flag AND control bit 2 (interrupt enable). `irqVector` shows the stored vector at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| standbyEnter | input | 1 | Full standby entry; clears the channel enable |
| modStandby | input | 1 | Module standby; freezes the block |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (arms the end-flag clear) |
| regAddr | input | 2 | Register select: 0 control, 1 count, 2 vector |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| masterEn | input | 1 | Global master enable |
| nmiFlag | input | 1 | Global NMI flag |
| addrErrFlag | input | 1 | Global address-error flag |
| reqMode | input | 1 | 0 auto mode, 1 request mode |
| xferReq | input | 1 | Transfer request in request mode |
| xferDone | input | 1 | One-cycle end-of-unit strobe from the data path |
| xferBusy | output | 1 | A transfer unit is in progress |
| irqOut | output | 1 | Transfer-end interrupt |
| irqVector | output | 8 | Interrupt vector |

## Verification
Register writes, read arming, start decisions and done strobes all act at the clock edge that samples them. `xferBusy`, the registers and `irqOut` therefore show the result at that same edge, and `regRdData` follows `regAddr` with no delay. The bench drives inputs just after a rising edge. It advances a behavioural model on each rising edge and compares every output against the model at the following falling edge, exactly one edge after the stimulus. Directed checks read registers or sample the outputs at the same point.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_VEC  = 2'd2;
  localparam int BIT_EN  = 0;
  localparam int BIT_END = 1;
  localparam int BIT_IE  = 2;

  typedef struct packed {
    logic decCount;
    logic setEnd;
  } chanStrobe_t;

  typedef enum logic {ST_IDLE, ST_ACTIVE} seqState_t;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int VEC_W  = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              standbyEnter,
  input  logic              modStandby,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  chanStrobe_t       strobe,
  output logic              chanEn,
  output logic              endFlag,
  output logic              irqEn,
  output logic              cntZero,
  output logic              cntOne,
  output logic [VEC_W-1:0]  vecOut
);
  localparam int CNT_PAD = DATA_W - CNT_W;
  localparam int VEC_PAD = DATA_W - VEC_W;

  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             wrCtl, wrCnt, wrVec, rdCtl;

  assign wrCtl = regWrEn && !modStandby && (regAddr == ADDR_CTRL);
  assign wrCnt = regWrEn && !modStandby && (regAddr == ADDR_CNT);
  assign wrVec = regWrEn && !modStandby && (regAddr == ADDR_VEC);
  assign rdCtl = regRdEn && !modStandby && (regAddr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             chanEn <= 1'b0;
    else if (standbyEnter) chanEn <= 1'b0;
    else if (wrCtl)        chanEn <= regWrData[BIT_EN];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      irqEn <= 1'b0;
    else if (wrCtl) irqEn <= regWrData[BIT_IE];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              endFlag <= 1'b0;
    else if (strobe.setEnd) endFlag <= 1'b1;
    else if (wrCtl && armed && !regWrData[BIT_END]) endFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   armed <= 1'b0;
    else if (wrCtl)              armed <= 1'b0;
    else if (rdCtl && endFlag)   armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (wrCnt)           cnt <= regWrData[CNT_W-1:0];
    else if (strobe.decCount) cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wrVec) vecOut <= regWrData[VEC_W-1:0];
  end

  assign cntZero = (cnt == '0);
  assign cntOne  = (cnt == CNT_W'(1));

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdData[BIT_EN]  = chanEn;
        regRdData[BIT_END] = endFlag;
        regRdData[BIT_IE]  = irqEn;
      end
      ADDR_CNT: regRdData = {{CNT_PAD{1'b0}}, cnt};
      ADDR_VEC: regRdData = {{VEC_PAD{1'b0}}, vecOut};
      default:  regRdData = '0;
    endcase
  end

  // R6
  endHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    endFlag && !armed |=> endFlag);
  // R5
  endSet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !endFlag && !strobe.setEnd |=> !endFlag);
  // R8
  standbyClr_chk: assert property (@(posedge clk) disable iff (!rstN)
    standbyEnter |=> !chanEn);
  // R9
  vecUpper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_VEC) |-> (regRdData[DATA_W-1:VEC_W] == '0));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modStandby,
  input  logic        reqMode,
  input  logic        xferReq,
  input  logic        xferDone,
  input  logic        masterEn,
  input  logic        nmiFlag,
  input  logic        addrErrFlag,
  input  logic        chanEn,
  input  logic        endFlag,
  input  logic        cntZero,
  input  logic        cntOne,
  output chanStrobe_t strobe,
  output logic        xferBusy
);
  seqState_t state, stateNxt;
  logic      aborted, abortedNxt;
  logic      gateOk, startOk, abortNow;

  assign gateOk   = chanEn && masterEn && !nmiFlag && !addrErrFlag;
  assign startOk  = gateOk && !endFlag && !cntZero && (!reqMode || xferReq);
  assign abortNow = aborted || !gateOk;

  always_comb begin
    stateNxt   = state;
    abortedNxt = aborted;
    strobe     = '0;
    if (!modStandby) begin
      case (state)
        ST_IDLE: if (startOk) stateNxt = ST_ACTIVE;
        ST_ACTIVE: begin
          if (xferDone) begin
            strobe.decCount = 1'b1;
            strobe.setEnd   = cntOne && !abortNow;
            stateNxt        = ST_IDLE;
            abortedNxt      = 1'b0;
          end else if (!gateOk) begin
            abortedNxt = 1'b1;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      aborted <= 1'b0;
    end else begin
      state   <= stateNxt;
      aborted <= abortedNxt;
    end
  end

  assign xferBusy = (state == ST_ACTIVE);

  // R7
  busyHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferBusy && !(xferDone && !modStandby) |=> xferBusy);
  // R4
  gateBlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !xferBusy && (!chanEn || !masterEn || nmiFlag || addrErrFlag || endFlag) |=> !xferBusy);
  // R7
  abortNoEnd_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferBusy && !chanEn && xferDone |-> !strobe.setEnd);
  // R5
  decOnlyBusy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !xferBusy |-> !strobe.decCount);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int VEC_W  = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              standbyEnter,
  input  logic              modStandby,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              masterEn,
  input  logic              nmiFlag,
  input  logic              addrErrFlag,
  input  logic              reqMode,
  input  logic              xferReq,
  input  logic              xferDone,
  output logic              xferBusy,
  output logic              irqOut,
  output logic [VEC_W-1:0]  irqVector
);
  chanStrobe_t strobe;
  logic chanEn, endFlag, irqEn, cntZero, cntOne;

  dma_chan_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rstN(rstN), .standbyEnter(standbyEnter), .modStandby(modStandby),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strobe(strobe),
    .chanEn(chanEn), .endFlag(endFlag), .irqEn(irqEn),
    .cntZero(cntZero), .cntOne(cntOne), .vecOut(irqVector)
  );

  dma_chan_seq u_seq (
    .clk(clk), .rstN(rstN), .modStandby(modStandby), .reqMode(reqMode),
    .xferReq(xferReq), .xferDone(xferDone), .masterEn(masterEn),
    .nmiFlag(nmiFlag), .addrErrFlag(addrErrFlag), .chanEn(chanEn),
    .endFlag(endFlag), .cntZero(cntZero), .cntOne(cntOne),
    .strobe(strobe), .xferBusy(xferBusy)
  );

  assign irqOut = endFlag && irqEn;

  // R10
  irqNeedsEnd_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (regAddr != ADDR_CTRL) || regRdData[BIT_END]);
endmodule

// File: tb/dma_chan_ctrl_bench.sv
`timescale 1ns/1ps
module dma_chan_ctrl_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0, standbyEnter = 1'b0, modStandby = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        masterEn = 1'b0, nmiFlag = 1'b0, addrErrFlag = 1'b0;
  logic        reqMode = 1'b0, xferReq = 1'b0, xferDone = 1'b0;
  logic        xferBusy, irqOut;
  logic [7:0]  irqVector;

  dma_chan_ctrl u_dma_chan_ctrl (
    .clk(clk), .rstN(rstN), .standbyEnter(standbyEnter), .modStandby(modStandby),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .masterEn(masterEn), .nmiFlag(nmiFlag),
    .addrErrFlag(addrErrFlag), .reqMode(reqMode), .xferReq(xferReq),
    .xferDone(xferDone), .xferBusy(xferBusy), .irqOut(irqOut), .irqVector(irqVector)
  );

  int errors = 0, checks = 0;
  bit running = 1'b0, reported = 1'b0;
  string phase = "R1";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit mEn, mEnd, mIe, mArm, mBusy, mAbort, mVecKnown;
  int mCnt;
  logic [7:0] mVec;
  bit g, oEnd, oArm, oBusy, oAbort, dec, setE, wCtl, wCnt, wVec, rCtl;
  int oCnt;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mEn = 0; mEnd = 0; mIe = 0; mArm = 0; mBusy = 0; mAbort = 0; mCnt = 0;
    end else begin
      if (!modStandby) begin
        oEnd = mEnd; oArm = mArm; oBusy = mBusy; oAbort = mAbort; oCnt = mCnt;
        g = mEn && masterEn && !nmiFlag && !addrErrFlag;
        wCtl = regWrEn && regAddr == 2'd0;
        wCnt = regWrEn && regAddr == 2'd1;
        wVec = regWrEn && regAddr == 2'd2;
        rCtl = regRdEn && regAddr == 2'd0;
        dec = 0; setE = 0;
        if (oBusy) begin
          if (xferDone) begin
            dec = 1; setE = (oCnt == 1) && !(oAbort || !g);
            mBusy = 0; mAbort = 0;
          end else if (!g) mAbort = 1;
        end else if (g && !oEnd && oCnt != 0 && (!reqMode || xferReq)) mBusy = 1;
        if (wCtl) begin mEn = regWrData[0]; mIe = regWrData[2]; end
        if (setE) mEnd = 1;
        else if (wCtl && oArm && !regWrData[1]) mEnd = 0;
        if (wCtl) mArm = 0; else if (rCtl && oEnd) mArm = 1;
        if (wCnt) mCnt = int'(regWrData[15:0]); else if (dec) mCnt = oCnt - 1;
        if (wVec) begin mVec = regWrData[7:0]; mVecKnown = 1; end
      end
      if (standbyEnter) mEn = 0;
    end
  end

  always @(negedge clk) begin
    if (running) begin
      logic [31:0] expRd;
      bit known;
      chk(xferBusy == mBusy, {phase, " busy"}, 32'(xferBusy), 32'(mBusy));
      chk(irqOut == (mEnd && mIe), {phase, " irqOut"}, 32'(irqOut), 32'(mEnd && mIe));
      if (mVecKnown) chk(irqVector == mVec, {phase, " irqVector"}, 32'(irqVector), 32'(mVec));
      known = 1;
      case (regAddr)
        2'd0: expRd = {29'd0, mIe, mEnd, mEn};
        2'd1: expRd = 32'(mCnt);
        2'd2: begin expRd = {24'd0, mVec}; known = mVecKnown; end
        default: expRd = '0;
      endcase
      if (known) chk(regRdData == expRd, {phase, " regRdData"}, regRdData, expRd);
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic ticks(input int n); for (int i = 0; i < n; i++) tick(); endtask
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1; regAddr = a; regWrData = d; tick(); regWrEn = 0;
  endtask
  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regRdEn = 1; regAddr = a; @(negedge clk); d = regRdData; tick(); regRdEn = 0;
  endtask
  task automatic pulse(); xferDone = 1; tick(); xferDone = 0; endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
  end

  initial begin
    logic [31:0] d;
    ticks(3);
    running = 1;
    rstN = 1; tick();
    // R1 reset state
    phase = "R1";
    rd(2'd0, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(2'd1, d); chk(d == 0, "R1 count", d, 0);
    chk(xferBusy == 0 && irqOut == 0, "R1 outputs", {xferBusy, irqOut}, 0);
    // R9 vector width
    phase = "R9";
    wr(2'd2, 32'hFFFF_FFA5);
    rd(2'd2, d); chk(d == 32'h0000_00A5, "R9 vector", d, 32'hA5);
    chk(irqVector == 8'hA5, "R10 vector output", irqVector, 8'hA5);
    // R2 auto mode, R5 countdown, R10 irq
    phase = "R2";
    masterEn = 1; reqMode = 0;
    wr(2'd1, 3);
    wr(2'd0, 32'h5);
    tick(); chk(xferBusy == 1, "R2 auto start", xferBusy, 1);
    phase = "R5";
    for (int i = 0; i < 3; i++) begin pulse(); tick(); end
    chk(xferBusy == 0, "R5 busy after last unit", xferBusy, 0);
    chk(irqOut == 1, "R10 irq on end", irqOut, 1);
    rd(2'd0, d); chk(d == 32'h7, "R5 end flag set", d, 7);
    rd(2'd1, d); chk(d == 0, "R5 count zero", d, 0);
    // R6 clear handshake
    phase = "R6";
    wr(2'd0, 32'h7);
    wr(2'd0, 32'h5);
    chk(irqOut == 1, "R6 write without read keeps end", irqOut, 1);
    rd(2'd0, d);
    wr(2'd0, 32'h4);
    chk(irqOut == 0, "R6 cleared after read-then-write", irqOut, 0);
    rd(2'd0, d); chk(d == 32'h4, "R6 ctrl", d, 4);
    // R3 request mode
    phase = "R3";
    reqMode = 1;
    wr(2'd1, 2);
    wr(2'd0, 32'h1);
    ticks(3); chk(xferBusy == 0, "R3 no start without request", xferBusy, 0);
    xferReq = 1; tick(); xferReq = 0;
    chk(xferBusy == 1, "R3 start on request", xferBusy, 1);
    pulse(); tick();
    // R4 gates
    phase = "R4";
    reqMode = 0; nmiFlag = 1;
    ticks(3); chk(xferBusy == 0, "R4 nmi blocks", xferBusy, 0);
    nmiFlag = 0; addrErrFlag = 1;
    ticks(3); chk(xferBusy == 0, "R4 address error blocks", xferBusy, 0);
    addrErrFlag = 0; masterEn = 0;
    ticks(3); chk(xferBusy == 0, "R4 master off blocks", xferBusy, 0);
    masterEn = 1; tick();
    chk(xferBusy == 1, "R4 start once gates open", xferBusy, 1);
    // R7 abort
    phase = "R7";
    wr(2'd0, 32'h0);
    ticks(2); chk(xferBusy == 1, "R7 unit completes", xferBusy, 1);
    pulse(); ticks(2);
    chk(xferBusy == 0, "R7 halted", xferBusy, 0);
    rd(2'd0, d); chk(d == 0, "R7 no end flag", d, 0);
    rd(2'd1, d); chk(d == 0, "R7 count decremented", d, 0);
    // R8 standby
    phase = "R8";
    masterEn = 0;
    wr(2'd1, 5);
    wr(2'd0, 32'h1);
    standbyEnter = 1; tick(); standbyEnter = 0;
    rd(2'd0, d); chk(d == 0, "R8 standby clears enable", d, 0);
    modStandby = 1;
    wr(2'd0, 32'h5);
    wr(2'd1, 9);
    rd(2'd0, d); chk(d == 0, "R8 ctrl frozen", d, 0);
    rd(2'd1, d); chk(d == 5, "R8 count frozen", d, 5);
    modStandby = 0;
    wr(2'd0, 32'h1);
    modStandby = 1; masterEn = 1;
    ticks(3); chk(xferBusy == 0, "R8 no start in module standby", xferBusy, 0);
    modStandby = 0; masterEn = 0; tick();
    // R9 retention across reset
    phase = "R9";
    wr(2'd2, 32'h0000_013C);
    rstN = 0; ticks(2); rstN = 1; tick();
    rd(2'd2, d); chk(d == 32'h3C, "R9 vector survives reset", d, 32'h3C);
    rd(2'd3, d); chk(d == 0, "R9 unused address", d, 0);
    rd(2'd0, d); chk(d == 0, "R1 ctrl after second reset", d, 0);
    ticks(2);
    report();
  end
endmodule